// File: doc/BRIEF.md
# Exception capture and vectoring unit

This unit sits beside a multi-cycle processor controller and turns fault conditions into a redirect. Three request lines report an undefined opcode, an arithmetic overflow and a data address that is not word aligned. When more than one is raised in the same cycle, a fixed priority picks a single winner. The unit always drives the address that the program counter should jump to. On the controller's write strobes it records the faulting instruction address in a 32-bit EPC register and the winning cause code in a 32-bit Cause register. Both registers are visible on output ports so that handler code, or a return sequence, can read them.

A mode input selects between two ways of finding the handler. In cause-register mode every exception goes to one fixed handler address, and that handler reads Cause to learn what happened. In vectored mode each exception type has its own entry point. The entry points are 32 bytes apart, counted from a vector base, and the Cause register is left alone. Both the handler address and the vector base are parameters.

Top module: `exc_vector_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both the EPC and the Cause registers read zero.
- R2: When the EPC strobe is high at a clock edge, EPC holds the value of the fault address input from that cycle, starting on the next cycle.
- R3: When the EPC strobe is low at a clock edge, EPC keeps its value.
- R4: Each request maps to a cause code: undefined instruction is 0, overflow is 1, unaligned data address is 4. When several requests are high together, undefined instruction beats overflow, and overflow beats unaligned address.
- R5: When the mode input is low (cause-register mode), the handler address output equals the fixed handler parameter (default 0x80000180) in the same cycle, whatever requests are raised.
- R6: When the mode input is high (vectored mode) and at least one request is raised, the handler address equals the vector base (default 0x80000000) plus 32 times the winning cause code, in the same cycle.
- R7: In cause-register mode, a Cause strobe at a clock edge while a request is raised writes the winning code, zero-extended, into Cause on the next cycle.
- R8: In vectored mode the Cause strobe has no effect, and Cause keeps its value.
- R9: A Cause strobe with no request raised leaves Cause unchanged.
- R10: With no request raised, the handler address equals the fixed handler parameter in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_undef | input | 1 | Undefined-opcode condition |
| req_ovf | input | 1 | Arithmetic overflow condition |
| req_unalign | input | 1 | Data address not a multiple of 4 |
| vec_mode | input | 1 | 1 = vectored targets, 0 = single handler plus Cause |
| fault_pc | input | 32 | Address of the faulting instruction (PC minus 4) |
| epc_we | input | 1 | Strobe that captures fault_pc into EPC |
| cause_we | input | 1 | Strobe that captures the cause code into Cause |
| handler_pc | output | 32 | Next-PC handler address |
| epc_o | output | 32 | EPC register contents |
| cause_o | output | 32 | Cause register contents |

## Verification
The bench raises every combination of the three requests, so a priority encoder with two entries swapped would send a vectored jump to the wrong 32-byte slot and would also store the wrong code. It asserts the Cause strobe in vectored mode and with no request raised. A design that ignored mode or request validity there would overwrite Cause with a stale or default code. It toggles the mode while requests are held steady, which catches a target generator that keeps using the vector base in cause-register mode, or that jumps to the entry for code 0 when nothing is pending. It also asserts the EPC and Cause strobes separately, so that a design that tied them together would load one register on the other's strobe.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
    localparam int CODE_W = 3;
    localparam int N_REQ  = 3;

    typedef enum logic [CODE_W-1:0] {
        EXC_UNDEF   = 3'd0,
        EXC_OVF     = 3'd1,
        EXC_UNALIGN = 3'd4
    } exc_code_e;

    // request index (priority order, lowest index wins) to cause code
    function automatic exc_code_e code_of_index(input int idx);
        case (idx)
            0:       return EXC_UNDEF;
            1:       return EXC_OVF;
            default: return EXC_UNALIGN;
        endcase
    endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_vec_pkg::*;
(
    input  logic [N_REQ-1:0]  req,
    output logic              valid,
    output exc_code_e         code
);
    always_comb begin
        valid = |req;
        code  = EXC_UNDEF;
        // scan from lowest priority up so the highest-priority request lands last
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                code = code_of_index(i);
            end
        end
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_vec_pkg::*;
#(
    parameter int               XLEN          = 32,
    parameter int               STRIDE_LG     = 5,
    parameter logic [XLEN-1:0]  FIXED_HANDLER = 32'h8000_0180,
    parameter logic [XLEN-1:0]  VEC_BASE      = 32'h8000_0000
) (
    input  logic             vec_mode,
    input  logic             valid,
    input  exc_code_e        code,
    output logic [XLEN-1:0]  handler
);
    logic [XLEN-1:0] offset;

    always_comb begin
        offset = XLEN'(code) << STRIDE_LG;
        if (vec_mode && valid) begin
            handler = VEC_BASE + offset;
        end else begin
            handler = FIXED_HANDLER;
        end
    end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_vec_pkg::*;
#(
    parameter int               XLEN          = 32,
    parameter int               STRIDE_LG     = 5,
    parameter logic [XLEN-1:0]  FIXED_HANDLER = 32'h8000_0180,
    parameter logic [XLEN-1:0]  VEC_BASE      = 32'h8000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_undef,
    input  logic             req_ovf,
    input  logic             req_unalign,
    input  logic             vec_mode,
    input  logic [XLEN-1:0]  fault_pc,
    input  logic             epc_we,
    input  logic             cause_we,
    output logic [XLEN-1:0]  handler_pc,
    output logic [XLEN-1:0]  epc_o,
    output logic [XLEN-1:0]  cause_o
);
    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
    } regs_t;

    regs_t      st_d, st_q;
    logic       pend;
    exc_code_e  win_code;

    exc_prio u_prio (
        .req   ({req_unalign, req_ovf, req_undef}),
        .valid (pend),
        .code  (win_code)
    );

    exc_target #(
        .XLEN          (XLEN),
        .STRIDE_LG     (STRIDE_LG),
        .FIXED_HANDLER (FIXED_HANDLER),
        .VEC_BASE      (VEC_BASE)
    ) u_target (
        .vec_mode (vec_mode),
        .valid    (pend),
        .code     (win_code),
        .handler  (handler_pc)
    );

    always_comb begin
        st_d = st_q;
        if (epc_we) begin
            st_d.epc = fault_pc;
        end
        if (cause_we && !vec_mode && pend) begin
            st_d.cause = XLEN'(win_code);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign epc_o   = st_q.epc;
    assign cause_o = st_q.cause;
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
    parameter int               XLEN          = 32,
    parameter int               STRIDE_LG     = 5,
    parameter logic [XLEN-1:0]  FIXED_HANDLER = 32'h8000_0180,
    parameter logic [XLEN-1:0]  VEC_BASE      = 32'h8000_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_undef,
    input logic             req_ovf,
    input logic             req_unalign,
    input logic             vec_mode,
    input logic [XLEN-1:0]  fault_pc,
    input logic             epc_we,
    input logic             cause_we,
    input logic [XLEN-1:0]  handler_pc,
    input logic [XLEN-1:0]  epc_o,
    input logic [XLEN-1:0]  cause_o
);
    logic any_req;
    assign any_req = req_undef | req_ovf | req_unalign;

    p_epc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(epc_we) && $past(rst_n) |-> epc_o == $past(fault_pc));

    p_epc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(epc_we) |-> $stable(epc_o));

    p_undef_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_mode && req_undef |-> handler_pc == VEC_BASE);

    p_fixed_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_mode |-> handler_pc == FIXED_HANDLER);

    p_vec_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_mode && any_req |-> handler_pc[STRIDE_LG-1:0] == '0);

    p_cause_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o == '0 || cause_o == XLEN'(1) || cause_o == XLEN'(4));

    p_cause_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vec_mode) |-> $stable(cause_o));

    p_cause_noreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_undef | req_ovf | req_unalign) |-> $stable(cause_o));

    p_idle_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |-> handler_pc == FIXED_HANDLER);
endmodule

bind exc_vector_unit exc_vector_unit_chk #(
    .XLEN          (XLEN),
    .STRIDE_LG     (STRIDE_LG),
    .FIXED_HANDLER (FIXED_HANDLER),
    .VEC_BASE      (VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_undef   (req_undef),
    .req_ovf     (req_ovf),
    .req_unalign (req_unalign),
    .vec_mode    (vec_mode),
    .fault_pc    (fault_pc),
    .epc_we      (epc_we),
    .cause_we    (cause_we),
    .handler_pc  (handler_pc),
    .epc_o       (epc_o),
    .cause_o     (cause_o)
);

// File: tb/exc_vector_unit_test.sv
`timescale 1ns/1ps
module exc_vector_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_undef = 1'b0, req_ovf = 1'b0, req_unalign = 1'b0;
    logic        vec_mode = 1'b0;
    logic [31:0] fault_pc = '0;
    logic        epc_we = 1'b0, cause_we = 1'b0;
    logic [31:0] handler_pc, epc_o, cause_o;

    int total = 0;
    int bad   = 0;

    // reference state
    logic [31:0] m_epc   = '0;
    logic [31:0] m_cause = '0;

    always #2 clk = ~clk;

    exc_vector_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_undef(req_undef), .req_ovf(req_ovf), .req_unalign(req_unalign),
        .vec_mode(vec_mode), .fault_pc(fault_pc),
        .epc_we(epc_we), .cause_we(cause_we),
        .handler_pc(handler_pc), .epc_o(epc_o), .cause_o(cause_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_code();
        if (req_undef)   return 0;
        if (req_ovf)     return 1;
        return 4;
    endfunction

    function automatic logic [31:0] model_target();
        if (!(req_undef || req_ovf || req_unalign)) return 32'h8000_0180;
        if (!vec_mode) return 32'h8000_0180;
        return 32'h8000_0000 + 32 * model_code();
    endfunction

    // one cycle: called just after a negedge; drive, check target, update model
    task automatic step(input logic u, input logic o, input logic a, input logic vm,
                        input logic [31:0] pc, input logic ew, input logic cw, input string tag);
        req_undef = u; req_ovf = o; req_unalign = a;
        vec_mode = vm; fault_pc = pc; epc_we = ew; cause_we = cw;
        #1;
        check({tag, " handler"}, handler_pc, model_target());
        if (ew) m_epc = pc;
        if (cw && !vm && (u || o || a)) m_cause = 32'(model_code());
        @(negedge clk);
        check({tag, " epc"}, epc_o, m_epc);
        check({tag, " cause"}, cause_o, m_cause);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        epc_we = 1'b1; cause_we = 1'b1; req_ovf = 1'b1; fault_pc = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        check("R1 reset epc", epc_o, 32'h0);
        check("R1 reset cause", cause_o, 32'h0);
        epc_we = 1'b0; cause_we = 1'b0; req_ovf = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset epc", epc_o, 32'h0);
        check("R1 after reset cause", cause_o, 32'h0);

        // directed
        step(0,0,0,0,32'h0000_1000,1,0,"R2 epc load");
        step(0,0,0,0,32'h0000_2000,0,0,"R3 epc hold");
        step(1,1,1,1,32'h0,0,0,"R4 all three vectored");
        step(0,1,1,1,32'h0,0,0,"R4 ovf over unalign");
        step(0,0,1,1,32'h0,0,0,"R6 unalign slot");
        step(0,1,0,0,32'h0,0,1,"R5 R7 ovf cause write");
        step(0,0,1,0,32'h0,0,1,"R7 unalign cause write");
        step(1,0,1,0,32'h0000_3004,1,1,"R4 R7 undef wins");
        step(0,1,0,0,32'h0,0,1,"R7 back to ovf");
        step(0,0,1,1,32'h0,0,1,"R8 vectored cause ignored");
        step(0,0,0,0,32'h0,0,1,"R9 no request cause hold");
        step(0,0,0,1,32'h0,0,1,"R10 idle vectored target");
        step(0,0,0,0,32'h0,0,0,"R10 idle fixed target");

        // random sweep
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] r;
            r = 7'($urandom);
            step(r[0], r[1], r[2], r[3], $urandom, r[4], r[5] | r[6], "R2 R4 R5 R6 R7 R8 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule